// File: doc/BRIEF.md
# Synchronous Character Hunter with Loop-Mode Transmit Gate

This block sits at the front of a character-oriented synchronous receive channel. It shifts each enabled receive bit into a 16-bit window and compares the newest bits with a programmable sync pattern. The compare length depends on the line mode and a short-sync select input. When the window matches, the block declares character lock. From then on it marks every character boundary with a one-cycle strobe, until a hunt request sends it back to searching.

When the channel is in loop operation, the same block also controls transmitter start-up. Until the receiver has locked and reached the next character boundary, it forces the transmit line: mark (1) when no break is requested, space (0) when one is. At that boundary it releases the transmitter, pulses a break-clear strobe so the break setting is dropped, and stops overriding the line. Character assembly, CRC and the transmitter's own sync length are outside this block.

Top module: `sync_hunter`

## Requirements
- R1: After synchronous reset, `locked`, `char_strobe`, `tx_en`, `txd_ovr` and `brk_clr` are 0 and `txd_lvl` is 1.
- R2: The compare length is chosen by `mode` (0 async, 1 monosync, 2 bisync, 3 SDLC) and `short_sync`: monosync uses 8 bits, or 6 when short; bisync uses 16 bits, or 12 when short; SDLC always uses 8. Bits shift in with the newest bit at position 0, so the first bit of the sync word is compared with `sync_pat[N-1]`. `locked` rises at the clock edge that takes in the final matching bit.
- R3: A cycle with `rx_en` low neither shifts the window nor advances the boundary count.
- R4: In async mode the block never locks, and `loop_en` has no effect: `tx_en` is 1 and `txd_ovr` is 0.
- R5: A cycle with `hunt` high clears `locked` at the next edge, even if the same bit would complete a match.
- R6: `char_strobe` pulses when lock is taken and then after every C further enabled bits. C is 6 when `short_sync` is set in monosync or bisync, and 8 otherwise.
- R7: While loop operation is active (`loop_en` high in monosync or bisync) and the transmitter has not yet been released, `txd_ovr` is 1 and `txd_lvl` is the inverse of `break_req` from the previous cycle.
- R8: In loop operation the transmitter is released at the first character boundary after lock, not at the lock itself. At that edge `tx_en` rises, `txd_ovr` falls and `brk_clr` pulses for one cycle together with `char_strobe`.
- R9: Outside loop operation, `tx_en` is 1 and `txd_ovr` is 0 one edge later. Leaving loop operation discards any earlier release.
- R10: Once released, the transmitter stays enabled while loop operation stays active, even if the receiver later re-enters hunt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received serial bit |
| rx_en | input | 1 | Qualifies `rx_bit` for this cycle |
| mode | input | 2 | Line mode: 0 async, 1 monosync, 2 bisync, 3 SDLC |
| short_sync | input | 1 | Selects the short sync and character length |
| sync_pat | input | 16 | Sync pattern, low N bits compared |
| hunt | input | 1 | Drop lock and return to searching |
| loop_en | input | 1 | Loop operation select |
| break_req | input | 1 | Programmed break (line held at space) |
| locked | output | 1 | Character lock flag |
| char_strobe | output | 1 | One-cycle character boundary strobe |
| tx_en | output | 1 | Transmitter enable |
| txd_ovr | output | 1 | Transmit line is overridden by this block |
| txd_lvl | output | 1 | Level driven while overridden |
| brk_clr | output | 1 | One-cycle request to clear the programmed break |

## Verification
A wrong compare mask or bit order shows as `locked` rising one or more enabled bits early or late, or not at all. This appears at the edge of the final sync bit. A boundary counter that is off by one shifts `char_strobe` within the first character after lock. In loop operation the same error moves the `tx_en` rise and the `brk_clr` pulse with it. A release flag that is wrong shows as `txd_ovr` staying high, or dropping before any boundary, in the cycle after the expected boundary. A wrong reaction to hunt or mode shows as `locked` or `tx_en` holding a stale value one edge later.

// File: rtl/sh_pkg.sv
package sh_pkg;
  typedef enum logic [1:0] {
    LM_ASYNC = 2'd0,
    LM_MONO  = 2'd1,
    LM_BI    = 2'd2,
    LM_SDLC  = 2'd3
  } line_mode_e;
endpackage

// File: rtl/sh_lenpick.sv
module sh_lenpick #(
  parameter int LW         = 5,
  parameter int CW         = 4,
  parameter int MONO_LEN   = 8,
  parameter int MONO_SHORT = 6,
  parameter int BI_LEN     = 16,
  parameter int BI_SHORT   = 12,
  parameter int CHAR_LEN   = 8,
  parameter int CHAR_SHORT = 6
) (
  input  sh_pkg::line_mode_e mode,
  input  logic               short_sync,
  output logic [LW-1:0]      cmp_len,
  output logic [CW-1:0]      char_len,
  output logic               hunt_ok,
  output logic               sync_mode
);
  import sh_pkg::*;

  always_comb begin
    cmp_len   = LW'(MONO_LEN);
    char_len  = CW'(CHAR_LEN);
    hunt_ok   = 1'b1;
    sync_mode = 1'b0;
    unique case (mode)
      LM_ASYNC: hunt_ok = 1'b0;
      LM_MONO: begin
        sync_mode = 1'b1;
        cmp_len   = short_sync ? LW'(MONO_SHORT) : LW'(MONO_LEN);
        char_len  = short_sync ? CW'(CHAR_SHORT) : CW'(CHAR_LEN);
      end
      LM_BI: begin
        sync_mode = 1'b1;
        cmp_len   = short_sync ? LW'(BI_SHORT) : LW'(BI_LEN);
        char_len  = short_sync ? CW'(CHAR_SHORT) : CW'(CHAR_LEN);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sh_shifter.sv
module sh_shifter #(
  parameter int SR_W = 16,
  parameter int LW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bit_en,
  input  logic            bit_in,
  input  logic [SR_W-1:0] pat,
  input  logic [LW-1:0]   cmp_len,
  output logic            match
);
  logic [SR_W-1:0] win_q;
  logic [SR_W-1:0] win_d;
  logic [SR_W-1:0] mask;

  assign win_d = {win_q[SR_W-2:0], bit_in};
  assign mask  = ~({SR_W{1'b1}} << cmp_len);
  assign match = bit_en && (((win_d ^ pat) & mask) == '0);

  always_ff @(posedge clk) begin
    if (rst)         win_q <= '0;
    else if (bit_en) win_q <= win_d;
  end
endmodule

// File: rtl/sh_framer.sv
module sh_framer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          match,
  input  logic          hunt,
  input  logic          hunt_ok,
  input  logic [CW-1:0] char_len,
  output logic          locked,
  output logic          strobe,
  output logic          bnd_hit
);
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap    = cnt_q >= (char_len - CW'(1));
  assign bnd_hit = locked && hunt_ok && !hunt && bit_en && wrap;

  always_ff @(posedge clk) begin
    if (rst || !hunt_ok || hunt) begin
      locked <= 1'b0;
      cnt_q  <= '0;
      strobe <= 1'b0;
    end else if (!locked) begin
      strobe <= match;
      if (match) begin
        locked <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (bit_en) begin
      strobe <= wrap;
      cnt_q  <= wrap ? '0 : cnt_q + CW'(1);
    end else begin
      strobe <= 1'b0;
    end
  end
endmodule

// File: rtl/sh_loopgate.sv
module sh_loopgate (
  input  logic clk,
  input  logic rst,
  input  logic loop_act,
  input  logic bnd_hit,
  input  logic break_req,
  output logic tx_en,
  output logic txd_ovr,
  output logic txd_lvl,
  output logic brk_clr
);
  logic rel_q;
  logic rel_d;

  assign rel_d = loop_act && (rel_q || bnd_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q   <= 1'b0;
      tx_en   <= 1'b0;
      txd_ovr <= 1'b0;
      txd_lvl <= 1'b1;
      brk_clr <= 1'b0;
    end else begin
      rel_q   <= rel_d;
      tx_en   <= !loop_act || rel_d;
      txd_ovr <= loop_act && !rel_d;
      txd_lvl <= !break_req;
      brk_clr <= loop_act && !rel_q && bnd_hit;
    end
  end
endmodule

// File: rtl/sync_hunter.sv
module sync_hunter #(
  parameter int SR_W       = 16,
  parameter int MONO_LEN   = 8,
  parameter int MONO_SHORT = 6,
  parameter int BI_LEN     = 16,
  parameter int BI_SHORT   = 12,
  parameter int CHAR_LEN   = 8,
  parameter int CHAR_SHORT = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_bit,
  input  logic            rx_en,
  input  logic [1:0]      mode,
  input  logic            short_sync,
  input  logic [SR_W-1:0] sync_pat,
  input  logic            hunt,
  input  logic            loop_en,
  input  logic            break_req,
  output logic            locked,
  output logic            char_strobe,
  output logic            tx_en,
  output logic            txd_ovr,
  output logic            txd_lvl,
  output logic            brk_clr
);
  localparam int LW = $clog2(SR_W + 1);
  localparam int CW = $clog2(CHAR_LEN + 1);

  sh_pkg::line_mode_e mode_e;
  logic [LW-1:0] cmp_len;
  logic [CW-1:0] char_len;
  logic          hunt_ok;
  logic          sync_mode;
  logic          match;
  logic          bnd_hit;

  assign mode_e = sh_pkg::line_mode_e'(mode);

  sh_lenpick #(
    .LW(LW), .CW(CW),
    .MONO_LEN(MONO_LEN), .MONO_SHORT(MONO_SHORT),
    .BI_LEN(BI_LEN), .BI_SHORT(BI_SHORT),
    .CHAR_LEN(CHAR_LEN), .CHAR_SHORT(CHAR_SHORT)
  ) i_len (
    .mode(mode_e), .short_sync(short_sync), .cmp_len(cmp_len),
    .char_len(char_len), .hunt_ok(hunt_ok), .sync_mode(sync_mode)
  );

  sh_shifter #(.SR_W(SR_W), .LW(LW)) i_shift (
    .clk(clk), .rst(rst), .bit_en(rx_en), .bit_in(rx_bit),
    .pat(sync_pat), .cmp_len(cmp_len), .match(match)
  );

  sh_framer #(.CW(CW)) i_frame (
    .clk(clk), .rst(rst), .bit_en(rx_en), .match(match), .hunt(hunt),
    .hunt_ok(hunt_ok), .char_len(char_len), .locked(locked),
    .strobe(char_strobe), .bnd_hit(bnd_hit)
  );

  sh_loopgate i_gate (
    .clk(clk), .rst(rst), .loop_act(loop_en && sync_mode), .bnd_hit(bnd_hit),
    .break_req(break_req), .tx_en(tx_en), .txd_ovr(txd_ovr),
    .txd_lvl(txd_lvl), .brk_clr(brk_clr)
  );
endmodule

// File: rtl/sh_hunter_chk.sv
module sh_hunter_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       loop_en,
  input logic       hunt,
  input logic       locked,
  input logic       char_strobe,
  input logic       tx_en,
  input logic       txd_ovr,
  input logic       brk_clr
);
  // R5
  hunt_clears_chk: assert property (@(posedge clk) disable iff (rst)
    hunt |=> !locked);

  // R4
  async_nolock_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0) |=> !locked);

  // R6
  strobe_locked_chk: assert property (@(posedge clk) disable iff (rst)
    char_strobe |-> locked);

  // R7
  ovr_gates_tx_chk: assert property (@(posedge clk) disable iff (rst)
    txd_ovr |-> !tx_en);

  // R8
  brkclr_bnd_chk: assert property (@(posedge clk) disable iff (rst)
    brk_clr |-> (char_strobe && tx_en && !txd_ovr));

  // R8
  release_bnd_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_en) && $past(loop_en) && ($past(mode) == 2'd1 || $past(mode) == 2'd2))
      |-> char_strobe);
endmodule

bind sync_hunter sh_hunter_chk i_chk (
  .clk(clk), .rst(rst), .mode(mode), .loop_en(loop_en), .hunt(hunt),
  .locked(locked), .char_strobe(char_strobe), .tx_en(tx_en),
  .txd_ovr(txd_ovr), .brk_clr(brk_clr)
);

// File: tb/test_sync_hunter.sv
module test_sync_hunter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_bit = 1'b0, rx_en = 1'b0, short_sync = 1'b0, hunt = 1'b0;
  logic loop_en = 1'b0, break_req = 1'b0;
  logic [1:0] mode = 2'd1;
  logic [15:0] sync_pat = 16'h0;
  logic locked, char_strobe, tx_en, txd_ovr, txd_lvl, brk_clr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // model state
  logic [15:0] m_sr;
  logic m_lock, m_strobe, m_rel, m_txen, m_ovr, m_lvl, m_bclr;
  int m_cnt;

  always #10 clk = ~clk;

  sync_hunter i_sync_hunter (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_en(rx_en), .mode(mode),
    .short_sync(short_sync), .sync_pat(sync_pat), .hunt(hunt),
    .loop_en(loop_en), .break_req(break_req), .locked(locked),
    .char_strobe(char_strobe), .tx_en(tx_en), .txd_ovr(txd_ovr),
    .txd_lvl(txd_lvl), .brk_clr(brk_clr)
  );

  // R2: compare length from mode and short select
  function automatic int exp_len(logic [1:0] md, logic sh);
    case (md)
      2'd1: return sh ? 6 : 8;
      2'd2: return sh ? 12 : 16;
      default: return 8;
    endcase
  endfunction

  // R6: character length
  function automatic int exp_clen(logic [1:0] md, logic sh);
    return (sh && (md == 2'd1 || md == 2'd2)) ? 6 : 8;
  endfunction

  task automatic model_reset();
    m_sr = '0; m_lock = 0; m_strobe = 0; m_cnt = 0;
    m_rel = 0; m_txen = 0; m_ovr = 0; m_lvl = 1; m_bclr = 0;
  endtask

  task automatic model_step();
    logic [15:0] nsr, mask;
    logic match, hok, lact, bnd, reln;
    int n, c;
    n = exp_len(mode, short_sync);
    c = exp_clen(mode, short_sync);
    hok = (mode != 2'd0);
    lact = loop_en && (mode == 2'd1 || mode == 2'd2);
    nsr = {m_sr[14:0], rx_bit};
    mask = (n == 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
    match = rx_en && (((nsr ^ sync_pat) & mask) == 16'h0);
    bnd = m_lock && hok && !hunt && rx_en && (m_cnt >= c - 1);
    if (rx_en) m_sr = nsr;
    if (!hok || hunt) begin
      m_lock = 0; m_cnt = 0; m_strobe = 0;
    end else if (!m_lock) begin
      m_strobe = match;
      if (match) begin m_lock = 1; m_cnt = 0; end
    end else if (rx_en) begin
      m_strobe = (m_cnt >= c - 1);
      m_cnt = (m_cnt >= c - 1) ? 0 : m_cnt + 1;
    end else m_strobe = 0;
    reln = lact && (m_rel || bnd);
    m_bclr = lact && !m_rel && bnd;
    m_rel = reln;
    m_txen = !lact || reln;
    m_ovr = lact && !reln;
    m_lvl = !break_req;
  endtask

  task automatic chk(logic act, logic exp, string req, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(locked, m_lock, (mode == 2'd0) ? "R4" : "R2", "locked");
    chk(char_strobe, m_strobe, "R6", "char_strobe");
    chk(tx_en, m_txen, m_ovr ? "R7" : "R8", "tx_en");
    chk(txd_ovr, m_ovr, (loop_en && mode != 2'd0 && mode != 2'd3) ? "R7" : "R9", "txd_ovr");
    chk(brk_clr, m_bclr, "R8", "brk_clr");
    if (m_ovr) chk(txd_lvl, m_lvl, "R7", "txd_lvl");
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic send(logic b, logic en);
    rx_bit = b; rx_en = en;
    cyc();
    rx_en = 0;
  endtask

  // one hunt episode: random noise, the sync word MSB-first, then random data
  task automatic frame(logic [1:0] md, logic sh, logic lp, logic brk);
    int n;
    mode = md; short_sync = sh; loop_en = lp; break_req = brk;
    sync_pat = 16'($urandom);
    n = exp_len(md, sh);
    hunt = 1; cyc(); hunt = 0;
    for (int i = 0; i < int'($urandom_range(4, 20)); i++)
      send(1'($urandom), ($urandom_range(0, 9) < 8));
    for (int i = n - 1; i >= 0; i--) begin
      if ($urandom_range(0, 5) == 0) send(1'($urandom), 1'b0); // R3 gap
      send(sync_pat[i], 1'b1);
    end
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 99) == 0) hunt = 1; // R5, R10
      if ($urandom_range(0, 30) == 0) break_req = ~break_req;
      send(1'($urandom), ($urandom_range(0, 9) < 7));
      hunt = 0;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_abcd));
    model_reset();
    rst = 1; cyc(); cyc();
    // R1 reset state
    chk(locked, 1'b0, "R1", "locked"); chk(char_strobe, 1'b0, "R1", "char_strobe");
    chk(tx_en, 1'b0, "R1", "tx_en"); chk(txd_ovr, 1'b0, "R1", "txd_ovr");
    chk(brk_clr, 1'b0, "R1", "brk_clr"); chk(txd_lvl, 1'b1, "R1", "txd_lvl");
    rst = 0;

    // directed R2: monosync short locks on exactly 6 bits 101101
    mode = 2'd1; short_sync = 1; loop_en = 1; break_req = 1; sync_pat = 16'hFF2D;
    cyc();
    chk(txd_ovr, 1'b1, "R7", "ovr before lock"); chk(txd_lvl, 1'b0, "R7", "break level");
    for (int i = 5; i >= 0; i--) send(sync_pat[i], 1'b1);
    chk(locked, 1'b1, "R2", "6-bit lock");
    chk(tx_en, 1'b0, "R8", "no release at lock itself");
    // R3: disabled cycles hold the count
    for (int i = 0; i < 4; i++) send(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) send(1'b0, 1'b1);
    chk(char_strobe, 1'b0, "R3", "no strobe yet");
    send(1'b0, 1'b1);
    chk(brk_clr, 1'b1, "R8", "release pulse"); chk(tx_en, 1'b1, "R8", "released");
    // R9: leaving loop
    loop_en = 0; cyc(); chk(txd_ovr, 1'b0, "R9", "loop off");

    for (int r = 0; r < 6; r++)
      for (int md = 0; md < 4; md++)
        for (int sh = 0; sh < 2; sh++)
          frame(2'(md), 1'(sh), 1'($urandom_range(0, 3) != 0), 1'($urandom));

    // R4: async with loop requested never gates
    mode = 2'd0; loop_en = 1; cyc(); cyc();
    chk(tx_en, 1'b1, "R4", "async tx_en"); chk(txd_ovr, 1'b0, "R4", "async ovr");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) cycles <= cycles + 1;
endmodule